// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control around a 10-bit successive-approximation converter with eight analog inputs. Control inputs come from a register interface: a start strobe, a scan-mode bit, a 3-bit channel field, an external-trigger enable and a reference-enable bit. A separate input carries the external trigger pin. From these the block picks the channel or channel group to convert. It drives a start/channel handshake to the converter core and takes the core's done strobe and result back.

There is one result register and one "stored" flag for each channel. A flag is set when its channel's result is written and cleared when that channel is read. The block reports a busy flag and gives a one-cycle done pulse when a sequence ends. A write to the start strobe aborts any conversion in progress and restarts the sequence. A trigger edge that arrives during a conversion is ignored. A separate counter, sized from the clock frequency, holds a reference-ready status low for the fixed recovery time after the reference is switched on.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, done, converter start and every stored flag are 0. The default controls (scan 0, field 000) convert channel 0 only.
- R2: With scan at 0, field value n starts one conversion, on channel n only.
- R3: With scan at 1, field bit 2 selects the base channel (0 or 4). The group runs in ascending order from that base up to the channel number equal to the field (for example 011 gives 0,1,2,3 and 110 gives 4,5,6).
- R4: On the clock edge that samples the start strobe, busy rises and a one-cycle converter start is issued for the group's first channel.
- R5: A start strobe while busy abandons the current conversion and restarts at the group's first channel. A converter done strobe in that same cycle is discarded.
- R6: With trigger enable set, a falling edge on the trigger pin starts a sequence. The pin passes through a two-flop synchronizer and an edge detector, so busy rises on the third clock edge after the pin falls.
- R7: A trigger falling edge has no effect while busy, and no effect when trigger enable is 0.
- R8: A converter done strobe while busy writes its 10-bit result into the current channel's register and sets that channel's stored flag. The read port returns that register and flag.
- R9: A read strobe clears the addressed channel's stored flag, unless that channel is written in the same cycle, in which case the write wins.
- R10: When the last channel of the group completes, busy falls and done pulses high for exactly one cycle. Otherwise the next channel's converter start is issued.
- R11: After the reference enable rises, reference-ready stays low for ceil(CLK_HZ * RECOVER_NS / 1e9) cycles after the enable is registered, and then goes high. It is low whenever the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe (one-cycle write of the start bit) |
| scan_i | input | 1 | 1 = group scan, 0 = single channel |
| sel_i | input | 3 | Channel / group field |
| trig_en_i | input | 1 | Enables the external trigger |
| trig_pin_i | input | 1 | External trigger pin, asynchronous, active on falling edge |
| ref_en_i | input | 1 | Reference enable |
| ref_ready_o | output | 1 | Reference recovered and usable |
| conv_start_o | output | 1 | One-cycle start to the converter core |
| conv_ch_o | output | 3 | Channel for the converter core |
| conv_done_i | input | 1 | Converter core finished |
| conv_data_i | input | RES_W | Converter core result |
| rd_i | input | 1 | Read strobe for a result register |
| rd_ch_i | input | 3 | Channel to read |
| rd_data_o | output | RES_W | Result register of rd_ch_i |
| rd_valid_o | output | 1 | Stored flag of rd_ch_i |
| stored_o | output | 8 | All stored flags, bit n = channel n |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with CLK_HZ at 4 MHz and the default 3000 ns recovery time. This makes the reference wait 12 cycles, so the full recovery window can be observed cycle by cycle. The stand-in converter takes five cycles per conversion. That leaves time for a restart partway through a scan and for a trigger pulse while busy. RES_W stays at 10, and each result carries its channel number, so a result written into the wrong register shows up at the read port.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int ADC_NCH  = 8;
    localparam int ADC_CH_W = $clog2(ADC_NCH);

    typedef logic [ADC_CH_W-1:0] ch_idx_t;

    typedef struct packed {
        logic    busy;
        logic    done;
        logic    conv_go;
        ch_idx_t cur;
        ch_idx_t last;
    } seq_state_t;

    // First channel of the selected set: the field itself in single mode,
    // the base of the half selected by the top field bit in scan mode.
    function automatic ch_idx_t group_first(input logic scan, input ch_idx_t sel);
        ch_idx_t f;
        f = sel;
        if (scan) begin
            f = '0;
            f[ADC_CH_W-1] = sel[ADC_CH_W-1];
        end
        return f;
    endfunction
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    // [0] first sync stage, [1] second sync stage, [2] previous synced value
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign fall_o = sh_q[2] & ~sh_q[1];
endmodule

// File: rtl/adc_ref_timer.sv
module adc_ref_timer #(
    parameter int RCYC = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_en_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(RCYC + 2);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        t_d.en  = ref_en_i;
        if (ref_en_i && !t_q.en)
            t_d.cnt = CNT_W'(RCYC);
        else if (t_q.cnt != '0)
            t_d.cnt = t_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign ready_o = t_q.en && (t_q.cnt == '0);

    assert_not_ready_at_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.en) |-> !ready_o);
    assert_ready_after_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.en && ref_en_i && t_q.cnt == CNT_W'(1)) |=> ready_o);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  ch_idx_t            wr_ch_i,
    input  logic [RES_W-1:0]   wr_data_i,
    input  logic               rd_i,
    input  ch_idx_t            rd_ch_i,
    output logic [RES_W-1:0]   rd_data_o,
    output logic               rd_valid_o,
    output logic [ADC_NCH-1:0] stored_o
);
    logic [ADC_NCH-1:0][RES_W-1:0] res_d, res_q;
    logic [ADC_NCH-1:0]            stored_d, stored_q;

    always_comb begin
        res_d    = res_q;
        stored_d = stored_q;
        if (rd_i)
            stored_d[rd_ch_i] = 1'b0;
        if (wr_i) begin
            res_d[wr_ch_i]    = wr_data_i;
            stored_d[wr_ch_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q    <= '0;
            stored_q <= '0;
        end else begin
            res_q    <= res_d;
            stored_q <= stored_d;
        end
    end

    assign rd_data_o  = res_q[rd_ch_i];
    assign rd_valid_o = stored_q[rd_ch_i];
    assign stored_o   = stored_q;

    assert_write_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> stored_q[$past(wr_ch_i)]);
    assert_read_clears_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !(wr_i && wr_ch_i == rd_ch_i)) |=> !stored_q[$past(rd_ch_i)]);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  logic    scan_i,
    input  ch_idx_t sel_i,
    input  logic    trig_en_i,
    input  logic    trig_fall_i,
    input  logic    conv_done_i,
    output logic    busy_o,
    output logic    done_o,
    output logic    conv_start_o,
    output ch_idx_t conv_ch_o,
    output logic    wr_o,
    output ch_idx_t wr_ch_o
);
    seq_state_t st_d, st_q;
    logic       go;

    assign go = start_i || (trig_en_i && trig_fall_i && !st_q.busy);

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.conv_go = 1'b0;
        if (go) begin
            st_d.busy    = 1'b1;
            st_d.cur     = group_first(scan_i, sel_i);
            st_d.last    = sel_i;
            st_d.conv_go = 1'b1;
        end else if (st_q.busy && conv_done_i) begin
            if (st_q.cur == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cur     = st_q.cur + 1'b1;
                st_d.conv_go = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o       = st_q.busy;
    assign done_o       = st_q.done;
    assign conv_start_o = st_q.conv_go;
    assign conv_ch_o    = st_q.cur;
    assign wr_o         = st_q.busy && conv_done_i && !go;
    assign wr_ch_o      = st_q.cur;

    assert_start_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.busy && st_q.conv_go));
    assert_conv_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.conv_go |-> st_q.busy);
    assert_restart_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.cur == group_first($past(scan_i), $past(sel_i))));
    assert_cur_in_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cur <= st_q.last));
    assert_trig_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_fall_i && st_q.busy && !start_i && !conv_done_i) |=> ($stable(st_q.cur) && !st_q.conv_go));
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int CLK_HZ     = 50_000_000,
    parameter int RECOVER_NS = 3000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               scan_i,
    input  logic [2:0]         sel_i,
    input  logic               trig_en_i,
    input  logic               trig_pin_i,
    input  logic               ref_en_i,
    output logic               ref_ready_o,
    output logic               conv_start_o,
    output logic [2:0]         conv_ch_o,
    input  logic               conv_done_i,
    input  logic [RES_W-1:0]   conv_data_i,
    input  logic               rd_i,
    input  logic [2:0]         rd_ch_i,
    output logic [RES_W-1:0]   rd_data_o,
    output logic               rd_valid_o,
    output logic [7:0]         stored_o,
    output logic               busy_o,
    output logic               done_o
);
    localparam longint RCYC_L = (longint'(CLK_HZ) * longint'(RECOVER_NS) + 64'd999_999_999) / 64'd1_000_000_000;
    localparam int     RCYC   = (RCYC_L < 1) ? 1 : int'(RCYC_L);

    logic    trig_fall;
    logic    wr;
    ch_idx_t wr_ch;

    adc_trig_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (trig_pin_i),
        .fall_o (trig_fall)
    );

    adc_ref_timer #(.RCYC(RCYC)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_en_i (ref_en_i),
        .ready_o  (ref_ready_o)
    );

    adc_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .scan_i       (scan_i),
        .sel_i        (sel_i),
        .trig_en_i    (trig_en_i),
        .trig_fall_i  (trig_fall),
        .conv_done_i  (conv_done_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .conv_start_o (conv_start_o),
        .conv_ch_o    (conv_ch_o),
        .wr_o         (wr),
        .wr_ch_o      (wr_ch)
    );

    adc_result_bank #(.RES_W(RES_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr),
        .wr_ch_i    (wr_ch),
        .wr_data_i  (conv_data_i),
        .rd_i       (rd_i),
        .rd_ch_i    (rd_ch_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .stored_o   (stored_o)
    );

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy_o && !done_o && stored_o == '0));
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W      = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int RCYC       = 12;
    localparam int CONV_CYC   = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0, scan_i = 1'b0, trig_en_i = 1'b0;
    logic             trig_pin_i = 1'b1, ref_en_i = 1'b0;
    logic [2:0]       sel_i = 3'd0, rd_ch_i = 3'd0;
    logic             rd_i = 1'b0;
    logic             conv_done_i = 1'b0;
    logic [RES_W-1:0] conv_data_i = '0;
    logic             ref_ready_o, conv_start_o, rd_valid_o, busy_o, done_o;
    logic [2:0]       conv_ch_o;
    logic [RES_W-1:0] rd_data_o;
    logic [7:0]       stored_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(.RES_W(RES_W), .CLK_HZ(CLK_HZ), .RECOVER_NS(3000)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .scan_i(scan_i), .sel_i(sel_i),
        .trig_en_i(trig_en_i), .trig_pin_i(trig_pin_i), .ref_en_i(ref_en_i),
        .ref_ready_o(ref_ready_o), .conv_start_o(conv_start_o), .conv_ch_o(conv_ch_o),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i), .rd_i(rd_i), .rd_ch_i(rd_ch_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .stored_o(stored_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Stand-in converter core: result = {channel, running count}
    int       core_cnt = 0;
    int       core_ch  = 0;
    bit [6:0] core_seq = 7'd1;
    always @(posedge clk) begin
        conv_done_i <= 1'b0;
        if (!rst_n) begin
            core_cnt <= 0;
        end else if (conv_start_o) begin
            core_cnt <= CONV_CYC;
            core_ch  <= int'(conv_ch_o);
        end else if (core_cnt != 0) begin
            core_cnt <= core_cnt - 1;
            if (core_cnt == 1) begin
                conv_done_i <= 1'b1;
                conv_data_i <= {core_ch[2:0], core_seq};
                core_seq    <= core_seq + 7'd1;
            end
        end
    end

    // Behavioural reference model
    bit m_busy, m_done, m_cs, m_ren;
    int m_cur, m_last, m_cch, m_rcnt;
    bit m_s1, m_s2, m_s3;
    bit m_stored[8];
    int m_res[8];
    always @(posedge clk) begin
        bit fall, go;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cs = 0; m_cur = 0; m_last = 0; m_cch = 0;
            m_s1 = 1; m_s2 = 1; m_s3 = 1; m_ren = 0; m_rcnt = 0;
            foreach (m_stored[i]) begin m_stored[i] = 0; m_res[i] = 0; end
        end else begin
            fall = m_s3 && !m_s2;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_pin_i;
            if (ref_en_i && !m_ren) m_rcnt = RCYC;
            else if (m_rcnt != 0)   m_rcnt--;
            m_ren = ref_en_i;
            if (rd_i) m_stored[rd_ch_i] = 0;
            m_done = 0; m_cs = 0;
            go = start_i || (trig_en_i && fall && !m_busy);
            if (go) begin
                m_busy = 1;
                m_cur  = scan_i ? (int'(sel_i) & 4) : int'(sel_i);
                m_last = int'(sel_i);
                m_cs = 1; m_cch = m_cur;
            end else if (m_busy && conv_done_i) begin
                m_res[m_cur] = int'(conv_data_i);
                m_stored[m_cur] = 1;
                if (m_cur == m_last) begin
                    m_busy = 0; m_done = 1;
                end else begin
                    m_cur++; m_cs = 1; m_cch = m_cur;
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    int seq_q[$];
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int st;
            st = 0;
            foreach (m_stored[i]) st |= int'(m_stored[i]) << i;
            check(busy_o == m_busy, "R4 busy", busy_o, m_busy);
            check(done_o == m_done, "R10 done", done_o, m_done);
            check(conv_start_o == m_cs, "R4 conv_start", conv_start_o, m_cs);
            if (m_cs) check(int'(conv_ch_o) == m_cch, "R3 conv_ch", conv_ch_o, m_cch);
            check(int'(stored_o) == st, "R8 stored", stored_o, st);
            check(int'(rd_data_o) == m_res[rd_ch_i], "R8 rd_data", rd_data_o, m_res[rd_ch_i]);
            check(rd_valid_o == m_stored[rd_ch_i], "R9 rd_valid", rd_valid_o, m_stored[rd_ch_i]);
            check(ref_ready_o == (m_ren && m_rcnt == 0), "R11 ref_ready", ref_ready_o, m_ren && m_rcnt == 0);
            if (conv_start_o) seq_q.push_back(int'(conv_ch_o));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_start(input bit scan, input int sel);
        scan_i = scan; sel_i = 3'(sel); start_i = 1'b1;
        tick(1);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int k = 0; k < 300 && !seen; k++) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
        tick(1);
    endtask

    task automatic read_ch(input int ch);
        rd_ch_i = 3'(ch); rd_i = 1'b1;
        tick(1);
        rd_i = 1'b0;
    endtask

    task automatic check_seq(input string req, input int exp[$]);
        check(seq_q.size() == exp.size(), req, seq_q.size(), exp.size());
        for (int k = 0; k < exp.size() && k < seq_q.size(); k++)
            check(seq_q[k] == exp[k], req, seq_q[k], exp[k]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit seen;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: idle after reset, default controls convert channel 0
        check(!busy_o && !done_o && !conv_start_o, "R1 idle", busy_o, 0);
        check(stored_o == 8'h00, "R1 stored", stored_o, 0);
        seq_q.delete();
        do_start(scan_i, int'(sel_i));
        wait_done(seen);
        check(seen, "R10 done pulse", seen, 1);
        check_seq("R1 default channel", '{0});
        check(stored_o == 8'h01, "R8 stored after ch0", stored_o, 1);

        // R9: read clears the flag
        read_ch(0);
        check(!rd_valid_o, "R9 read clear", rd_valid_o, 0);

        // R2: fixed channel 5
        seq_q.delete();
        do_start(0, 5);
        wait_done(seen);
        check_seq("R2 fixed ch5", '{5});
        check(stored_o == 8'h20, "R2 stored", stored_o, 8'h20);

        // R3: scan groups
        seq_q.delete();
        do_start(1, 3);
        wait_done(seen);
        check_seq("R3 scan 011", '{0, 1, 2, 3});
        check(stored_o == 8'h2F, "R3 stored 011", stored_o, 8'h2F);
        for (int c = 0; c < 8; c++) read_ch(c);
        check(stored_o == 8'h00, "R9 all cleared", stored_o, 0);
        seq_q.delete();
        do_start(1, 6);
        wait_done(seen);
        check_seq("R3 scan 110", '{4, 5, 6});
        check(stored_o == 8'h70, "R3 stored 110", stored_o, 8'h70);

        // R5: restart while busy
        seq_q.delete();
        do_start(1, 7);
        while (seq_q.size() < 2) @(negedge clk);
        tick(1);
        do_start(1, 7);
        wait_done(seen);
        check_seq("R5 abort restart", '{4, 5, 4, 5, 6, 7});

        // R6: trigger start with sync latency
        seq_q.delete();
        trig_en_i = 1'b1; scan_i = 1'b0; sel_i = 3'd2;
        trig_pin_i = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(!busy_o, "R6 not yet busy", busy_o, 0);
        @(posedge clk);
        @(negedge clk);
        check(busy_o, "R6 busy on third edge", busy_o, 1);
        tick(1);
        trig_pin_i = 1'b1;
        wait_done(seen);
        check_seq("R6 trigger ch2", '{2});

        // R7: trigger while busy is ignored
        seq_q.delete();
        do_start(1, 7);
        tick(3);
        trig_pin_i = 1'b0;
        tick(3);
        trig_pin_i = 1'b1;
        wait_done(seen);
        tick(8);
        check_seq("R7 busy trigger ignored", '{4, 5, 6, 7});
        check(!busy_o, "R7 idle after", busy_o, 0);

        // R7: trigger disabled is ignored
        seq_q.delete();
        trig_en_i = 1'b0;
        trig_pin_i = 1'b0;
        tick(8);
        check(!busy_o, "R7 disabled trigger", busy_o, 0);
        check(seq_q.size() == 0, "R7 no conversion", seq_q.size(), 0);
        trig_pin_i = 1'b1;
        tick(4);

        // R11: reference recovery window
        ref_en_i = 1'b1;
        repeat (RCYC) @(posedge clk);
        @(negedge clk);
        check(!ref_ready_o, "R11 still recovering", ref_ready_o, 0);
        @(posedge clk);
        @(negedge clk);
        check(ref_ready_o, "R11 ready", ref_ready_o, 1);
        tick(1);
        ref_en_i = 1'b0;
        tick(1);
        check(!ref_ready_o, "R11 off", ref_ready_o, 0);

        tick(5);
        finish_run();
    end
endmodule